// File: doc/BRIEF.md
# Special-node polar subtree decoder

This block sits inside a polar successive-cancellation decoder that walks a pruned decoding tree. When the scheduler reaches a subtree, it hands over the subtree's frozen mask and its soft inputs (signed LLRs) and pulses a start strobe. The block works out which of five shapes the subtree has. For the four shapes that have a closed-form decision, it returns the subtree's partial-sum vector in one pass, without any descent to the leaves.

The four special shapes are as follows. An all-frozen node returns zeros. An all-information node takes hard decisions and applies the polar transform. A repetition node, whose only information leaf is the last one, takes the sign of the LLR sum. A single-parity-check node, whose only frozen leaf is the first one, takes hard decisions and repairs odd parity at the least reliable leaf. Any other mask is reported as a general node, and the scheduler has to recurse into it itself.

The node size is 2^k leaves, with k from 1 up to log2(MAX_NV). Leaf i uses frozen bit i, LLR slice i (bits i*LLR_W and up) and result bit i.

Top module: `polar_spnode_dec`

## Requirements
- R1: If every one of the N_v low mask bits is 1 (1 = frozen), the kind code is 0 and every result bit is 0.
- R2: If every one of the N_v low mask bits is 0, the kind code is 1. The result is the polar transform of the hard decisions h (h_i = 1 exactly when LLR_i is negative; zero gives 0), where result bit j is the XOR of h_i over every i whose index bits include all bits of j.
- R3: If only mask bit N_v-1 is 0, the kind code is 2. Every one of the N_v result bits equals 1 when the signed sum of the N_v LLRs is negative, and 0 otherwise (this includes a sum of zero).
- R4: If only mask bit 0 is 1, the kind code is 3. The result is the hard decisions; if their XOR is 1, the bit with the smallest |LLR| is inverted, and on a tie the lowest index wins.
- R5: Classification is tried in the order all-frozen, all-information, repetition, parity-check. So for N_v=2 the mask with only bit 0 set gives code 2. Any mask matching none of the four gives code 4 with an all-zero result.
- R6: `done_o` is a single-cycle pulse that rises exactly k+1 clock edges after the edge that samples `start_i`.
- R7: After a reset, `done_o`, `node_kind_o` and `beta_o` are all 0.
- R8: Mask bits and LLR slices at positions N_v and above do not affect the result, and result bits at positions N_v and above are 0.
- R9: A `start_i` pulse that arrives while a node is in progress is ignored. It changes neither the running result nor its timing, and no extra `done_o` follows.
- R10: `node_kind_o` and `beta_o` change only on the edge that raises `done_o`, and hold between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| nv_log2_i | input | $clog2(log2(MAX_NV)+1) | k, node size N_v = 2^k, valid 1..log2(MAX_NV) |
| frozen_i | input | MAX_NV | Frozen mask, bit i = 1 means leaf i is frozen |
| llr_i | input | MAX_NV*LLR_W | Signed LLR per leaf, leaf i in slice i |
| done_o | output | 1 | Result-valid pulse |
| node_kind_o | output | 3 | 0 all-frozen, 1 all-information, 2 repetition, 3 parity-check, 4 general |
| beta_o | output | MAX_NV | Partial-sum result, bit i for leaf i |

## Verification
The assertions assume that `nv_log2_i` lies between 1 and log2(MAX_NV) whenever a start is accepted. They also assume that the inputs are held steady only on the start edge, because the block captures them there. The stimulus always drives a legal k. It also scrambles the mask and LLR inputs right after every start, and it fills the positions above N_v with random data, so any dependence on late or unused inputs shows up in the result. Small node sizes are swept over every mask; the large sizes use the special masks plus general ones, with random, tied and extreme LLR values.

// File: rtl/polar_spnode_pkg.sv
// Shared definitions for the special-node polar decoder.
// Assumes: kind codes are visible at the top-level port and are fixed.
package polar_spnode_pkg;

    typedef enum logic [2:0] {
        KIND_ZERO   = 3'd0,
        KIND_FULL   = 3'd1,
        KIND_REPEAT = 3'd2,
        KIND_PARITY = 3'd3,
        KIND_OTHER  = 3'd4
    } node_kind_t;

endpackage

// File: rtl/polar_spnode_classify.sv
// Classifies a subtree from its frozen mask and builds the leaf mask.
// Assumes: nv_log2_i in 1..log2(MAX_NV); bits above N_v are don't-care.
module polar_spnode_classify
    import polar_spnode_pkg::*;
#(
    parameter int MAX_NV = 32,
    localparam int LOGN = $clog2(MAX_NV),
    localparam int K_W  = $clog2(LOGN + 1)
) (
    input  logic [MAX_NV-1:0] frozen_i,
    input  logic [K_W-1:0]    nv_log2_i,
    output logic [MAX_NV-1:0] leaf_mask_o,
    output node_kind_t        kind_o
);

    logic [MAX_NV-1:0] live_frz;
    logic [MAX_NV-1:0] last_leaf;

    // Mark leaves that belong to the node (index below 2^k).
    always_comb begin
        for (int i = 0; i < MAX_NV; i++) begin
            leaf_mask_o[i] = (32'(i) < (32'd1 << nv_log2_i));
        end
    end

    assign live_frz  = frozen_i & leaf_mask_o;
    assign last_leaf = leaf_mask_o & ~(leaf_mask_o >> 1);

    // Match the special shapes in fixed priority order.
    always_comb begin
        if (live_frz == leaf_mask_o)
            kind_o = KIND_ZERO;
        else if (live_frz == '0)
            kind_o = KIND_FULL;
        else if (live_frz == (leaf_mask_o & ~last_leaf))
            kind_o = KIND_REPEAT;
        else if (live_frz == MAX_NV'(1))
            kind_o = KIND_PARITY;
        else
            kind_o = KIND_OTHER;
    end

endmodule

// File: rtl/polar_spnode_eval.sv
// Produces the pre-transform result for a classified node: hard decisions,
// sign of the LLR sum, or parity-repaired hard decisions.
// Assumes: leaf_mask_i has the low N_v bits set; kind_i matches the mask.
module polar_spnode_eval
    import polar_spnode_pkg::*;
#(
    parameter int MAX_NV = 32,
    parameter int LLR_W  = 8,
    localparam int LOGN  = $clog2(MAX_NV),
    localparam int SUM_W = LLR_W + LOGN + 1,
    localparam int IDX_W = (LOGN > 0) ? LOGN : 1
) (
    input  logic [MAX_NV*LLR_W-1:0] llr_i,
    input  logic [MAX_NV-1:0]       leaf_mask_i,
    input  node_kind_t              kind_i,
    output logic [MAX_NV-1:0]       beta_o
);

    logic signed [LLR_W-1:0] lv [MAX_NV];
    logic [LLR_W:0]          mag [MAX_NV];
    logic [MAX_NV-1:0]       hard;
    logic signed [SUM_W-1:0] acc;
    logic [LLR_W:0]          best_mag;
    logic [IDX_W-1:0]        best_idx;
    logic                    odd;
    logic [MAX_NV-1:0]       flip;

    // Unpack each leaf, derive its sign decision and magnitude.
    for (genvar g = 0; g < MAX_NV; g++) begin : g_leaf
        logic signed [LLR_W:0] ext;
        assign lv[g]   = llr_i[g*LLR_W +: LLR_W];
        assign ext     = {lv[g][LLR_W-1], lv[g]};
        assign mag[g]  = ext[LLR_W] ? $unsigned(-ext) : $unsigned(ext);
        assign hard[g] = leaf_mask_i[g] & lv[g][LLR_W-1];
    end

    // Accumulate the signed sum over the live leaves.
    always_comb begin
        acc = '0;
        for (int i = 0; i < MAX_NV; i++) begin
            if (leaf_mask_i[i]) acc = acc + SUM_W'(lv[i]);
        end
    end

    // Locate the least reliable live leaf, first index on ties.
    always_comb begin
        best_mag = '1;
        best_idx = '0;
        for (int i = 0; i < MAX_NV; i++) begin
            if (leaf_mask_i[i] && (mag[i] < best_mag)) begin
                best_mag = mag[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    assign odd  = ^hard;
    assign flip = odd ? (MAX_NV'(1) << best_idx) : '0;

    // Select the result form by node kind.
    always_comb begin
        unique case (kind_i)
            KIND_FULL:   beta_o = hard;
            KIND_REPEAT: beta_o = acc[SUM_W-1] ? leaf_mask_i : '0;
            KIND_PARITY: beta_o = hard ^ flip;
            default:     beta_o = '0;
        endcase
    end

endmodule

// File: rtl/polar_butterfly_stage.sv
// One stage of the polar transform: for span 2^s, each lower leaf of a
// pair takes the XOR with its partner. The stage is picked at run time.
// Assumes: stage_i < log2(MAX_NV); other values pass the vector through.
module polar_butterfly_stage #(
    parameter int MAX_NV = 32,
    localparam int LOGN = $clog2(MAX_NV),
    localparam int K_W  = $clog2(LOGN + 1)
) (
    input  logic [MAX_NV-1:0] vec_i,
    input  logic [K_W-1:0]    stage_i,
    output logic [MAX_NV-1:0] vec_o
);

    logic [MAX_NV-1:0] per_stage [LOGN];

    for (genvar s = 0; s < LOGN; s++) begin : g_stage
        for (genvar i = 0; i < MAX_NV; i++) begin : g_bit
            if ((((i >> s) & 1) == 0) && (i + (1 << s) < MAX_NV)) begin : g_xor
                assign per_stage[s][i] = vec_i[i] ^ vec_i[i + (1 << s)];
            end else begin : g_pass
                assign per_stage[s][i] = vec_i[i];
            end
        end
    end

    // Route the requested stage to the output.
    always_comb begin
        vec_o = vec_i;
        for (int s = 0; s < LOGN; s++) begin
            if (stage_i == K_W'(s)) vec_o = per_stage[s];
        end
    end

endmodule

// File: rtl/polar_spnode_dec.sv
// Top of the special-node decoder. It captures a node on start, then
// classifies and evaluates it in the next cycle, then spends k cycles in
// the transform (applied to all-information nodes only) so that the
// latency depends on k alone, and finally publishes the result with a pulse.
// Assumes: nv_log2_i in 1..log2(MAX_NV) when start is accepted.
module polar_spnode_dec
    import polar_spnode_pkg::*;
#(
    parameter int MAX_NV = 32,
    parameter int LLR_W  = 8,
    localparam int LOGN = $clog2(MAX_NV),
    localparam int K_W  = $clog2(LOGN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [K_W-1:0]          nv_log2_i,
    input  logic [MAX_NV-1:0]       frozen_i,
    input  logic [MAX_NV*LLR_W-1:0] llr_i,
    output logic                    done_o,
    output logic [2:0]              node_kind_o,
    output logic [MAX_NV-1:0]       beta_o
);

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_XFORM} phase_t;

    phase_t                  phase;
    logic [K_W-1:0]          cap_k;
    logic [MAX_NV-1:0]       cap_frz;
    logic [MAX_NV*LLR_W-1:0] cap_llr;
    logic [K_W-1:0]          stage;
    node_kind_t              kind_q;
    logic [MAX_NV-1:0]       work;
    logic [MAX_NV-1:0]       leaf_mask;
    node_kind_t              kind_c;
    logic [MAX_NV-1:0]       eval_beta;
    logic [MAX_NV-1:0]       xform_out;
    logic                    last_stage;

    polar_spnode_classify #(.MAX_NV(MAX_NV)) classify_i (
        .frozen_i    (cap_frz),
        .nv_log2_i   (cap_k),
        .leaf_mask_o (leaf_mask),
        .kind_o      (kind_c)
    );

    polar_spnode_eval #(.MAX_NV(MAX_NV), .LLR_W(LLR_W)) eval_i (
        .llr_i       (cap_llr),
        .leaf_mask_i (leaf_mask),
        .kind_i      (kind_c),
        .beta_o      (eval_beta)
    );

    polar_butterfly_stage #(.MAX_NV(MAX_NV)) stage_i (
        .vec_i   (work),
        .stage_i (stage),
        .vec_o   (xform_out)
    );

    assign last_stage = (stage == cap_k - K_W'(1));

    // Sequence capture, evaluation, transform stages and publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= ST_IDLE;
            cap_k       <= K_W'(1);
            cap_frz     <= '0;
            cap_llr     <= '0;
            stage       <= '0;
            kind_q      <= KIND_ZERO;
            work        <= '0;
            done_o      <= 1'b0;
            node_kind_o <= '0;
            beta_o      <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (start_i) begin
                        cap_k   <= nv_log2_i;
                        cap_frz <= frozen_i;
                        cap_llr <= llr_i;
                        phase   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    kind_q <= kind_c;
                    work   <= eval_beta;
                    stage  <= '0;
                    phase  <= ST_XFORM;
                end
                ST_XFORM: begin
                    if (kind_q == KIND_FULL) work <= xform_out;
                    if (last_stage) begin
                        phase       <= ST_IDLE;
                        done_o      <= 1'b1;
                        node_kind_o <= kind_q;
                        beta_o      <= (kind_q == KIND_FULL) ? xform_out : work;
                    end else begin
                        stage <= stage + K_W'(1);
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/polar_spnode_dec_chk.sv
// Property checker for polar_spnode_dec, attached by bind below.
// Keeps its own model of acceptance and latency from the port activity.
module polar_spnode_dec_chk #(
    parameter int MAX_NV = 32,
    localparam int LOGN = $clog2(MAX_NV),
    localparam int K_W  = $clog2(LOGN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [K_W-1:0]    nv_log2_i,
    input logic              done_o,
    input logic [2:0]        node_kind_o,
    input logic [MAX_NV-1:0] beta_o
);

    logic              busy;
    logic [K_W:0]      left;
    logic              due;
    logic [K_W-1:0]    held_k;
    logic [MAX_NV-1:0] live;

    // Count down from an accepted start to the expected result edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left   <= '0;
            due    <= 1'b0;
            held_k <= K_W'(1);
        end else begin
            due <= busy && (left == (K_W+1)'(1));
            if (!busy && start_i) begin
                busy   <= 1'b1;
                left   <= (K_W+1)'(nv_log2_i) + (K_W+1)'(1);
                held_k <= nv_log2_i;
            end else if (busy) begin
                left <= left - (K_W+1)'(1);
                if (left == (K_W+1)'(1)) busy <= 1'b0;
            end
        end
    end

    // Leaves covered by the node held in the model.
    always_comb begin
        for (int i = 0; i < MAX_NV; i++) live[i] = (32'(i) < (32'd1 << held_k));
    end

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == due);

    p_no_extra_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_zero_node_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && node_kind_o == 3'd0) |-> beta_o == '0);

    p_repeat_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && node_kind_o == 3'd2) |-> (beta_o == '0 || beta_o == live));

    p_parity_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && node_kind_o == 3'd3) |-> ^beta_o == 1'b0);

    p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> node_kind_o <= 3'd4);

    p_upper_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beta_o & ~live) == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(beta_o) && $stable(node_kind_o)));

endmodule

bind polar_spnode_dec polar_spnode_dec_chk #(.MAX_NV(MAX_NV)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .nv_log2_i   (nv_log2_i),
    .done_o      (done_o),
    .node_kind_o (node_kind_o),
    .beta_o      (beta_o)
);

// File: tb/polar_spnode_dec_tb_top.sv
`timescale 1ns/1ps
// Bench for polar_spnode_dec: all masks for small nodes, special and
// general masks for large nodes, crafted tie/extreme LLR cases.
module polar_spnode_dec_tb_top;

    localparam int NV = 32;
    localparam int LW = 8;
    localparam int KW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [KW-1:0]    nv = 3'd1;
    logic [NV-1:0]    frz = '0;
    logic [NV*LW-1:0] llr = '0;
    logic             done;
    logic [2:0]       kind;
    logic [NV-1:0]    beta;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    polar_spnode_dec #(.MAX_NV(NV), .LLR_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .nv_log2_i(nv),
        .frozen_i(frz), .llr_i(llr), .done_o(done),
        .node_kind_o(kind), .beta_o(beta)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rnd(output logic [31:0] r);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        r = seed;
    endtask

    task automatic rnd_llr(output logic [NV*LW-1:0] v);
        logic [31:0] w;
        for (int i = 0; i < NV*LW/32; i++) begin
            rnd(w);
            v[i*32 +: 32] = w;
        end
    endtask

    // Expected kind from the counting form of the shape rules.
    function automatic int ref_kind(int k, logic [NV-1:0] f);
        int n = 1 << k;
        int cnt = 0;
        for (int i = 0; i < n; i++) cnt += int'(f[i]);
        if (cnt == n) return 0;
        if (cnt == 0) return 1;
        if (cnt == n - 1 && !f[n-1]) return 2;
        if (cnt == 1 && f[0]) return 3;
        return 4;
    endfunction

    // Expected result from the arithmetic definitions.
    function automatic logic [NV-1:0] ref_beta(int k, int kd, logic [NV*LW-1:0] l);
        int n = 1 << k;
        logic [NV-1:0] hd = '0;
        logic [NV-1:0] res = '0;
        int sum = 0;
        int best = 100000;
        int bi = 0;
        bit par = 0;
        for (int i = 0; i < n; i++) begin
            int v = $signed(l[i*LW +: LW]);
            int a = (v < 0) ? -v : v;
            hd[i] = (v < 0);
            sum += v;
            if (a < best) begin best = a; bi = i; end
            par ^= hd[i];
        end
        case (kd)
            1: for (int j = 0; j < n; j++) begin
                   bit x = 0;
                   for (int i = 0; i < n; i++) if ((i & j) == j) x ^= hd[i];
                   res[j] = x;
               end
            2: for (int j = 0; j < n; j++) res[j] = (sum < 0);
            3: begin res = hd; if (par) res[bi] = ~res[bi]; end
            default: res = '0;
        endcase
        return res;
    endfunction

    // Run one node; optionally poke start while busy (R9).
    task automatic run_node(input int k, input logic [NV-1:0] f,
                            input logic [NV*LW-1:0] l, input bit poke);
        int lat;
        int ek = ref_kind(k, f);
        logic [NV-1:0] eb = ref_beta(k, ek, l);
        logic [NV*LW-1:0] junk;
        string req;
        case (ek)
            0: req = "R1"; 1: req = "R2"; 2: req = "R3"; 3: req = "R4";
            default: req = "R5";
        endcase
        @(negedge clk);
        nv = KW'(k); frz = f; llr = l; start = 1'b1;
        @(negedge clk);
        rnd_llr(junk);
        frz = ~f; llr = junk;
        lat = 0;
        if (poke) begin
            nv = KW'((k % 5) + 1);
            @(negedge clk);
            lat = 1;
        end
        start = 1'b0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        check(lat == k + 1, poke ? "R9 latency" : "R6 latency", 64'(lat), 64'(k + 1));
        check(int'(kind) == ek, {req, " kind"}, 64'(kind), 64'(ek));
        check(beta == eb, poke ? "R9 result" : {req, " result"}, 64'(beta), 64'(eb));
        if (k < 5) check((beta >> (1 << k)) == '0, "R8 upper bits", 64'(beta), 64'(eb));
        @(negedge clk);
        check(!done, "R6 pulse width", 64'(done), 64'(0));
        if (poke) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                check(!done, "R9 no extra done", 64'(done), 64'(0));
            end
        end
        check(beta == eb, "R10 hold", 64'(beta), 64'(eb));
    endtask

    initial begin
        logic [NV*LW-1:0] l;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        check(!done, "R7 done after reset", 64'(done), 64'(0));
        check(kind == 3'd0, "R7 kind after reset", 64'(kind), 64'(0));
        check(beta == '0, "R7 result after reset", 64'(beta), 64'(0));
        rst_n = 1'b1;

        // Every mask for N_v = 2, 4, 8 with random upper garbage.
        for (int k = 1; k <= 3; k++) begin
            for (int p = 0; p < (1 << (1 << k)); p++) begin
                logic [NV-1:0] f;
                rnd(w);
                f = (w << (1 << k)) | NV'(p);
                rnd_llr(l);
                run_node(k, f, l, 1'b0);
            end
        end

        // R5: two-leaf mask with only leaf 0 frozen resolves to repetition.
        rnd_llr(l);
        run_node(1, 32'h0000_0001, l, 1'b0);
        check(kind == 3'd2, "R5 priority repetition over parity", 64'(kind), 64'(2));

        // Special and general masks for N_v = 16 and 32.
        for (int k = 4; k <= 5; k++) begin
            logic [NV-1:0] m = (k == 5) ? '1 : NV'((32'd1 << (1 << k)) - 1);
            for (int t = 0; t < 4; t++) begin
                rnd_llr(l); run_node(k, m, l, 1'b0);
                rnd_llr(l); run_node(k, '0, l, 1'b0);
                rnd_llr(l); run_node(k, m & ~(NV'(1) << ((1 << k) - 1)), l, 1'b0);
                rnd_llr(l); run_node(k, NV'(1), l, 1'b0);
                rnd(w);
                rnd_llr(l); run_node(k, (w & m) | NV'(3), l, 1'b0);
            end
        end

        // R4 tie: two leaves share the smallest magnitude, odd parity.
        l = '0;
        for (int i = 0; i < 8; i++) l[i*LW +: LW] = 8'sd40;
        l[2*LW +: LW] = -8'sd1;
        l[5*LW +: LW] = 8'sd1;
        run_node(3, 32'h0000_0001, l, 1'b0);
        check(beta[7:0] == 8'h00, "R4 tie lowest index", 64'(beta), 64'(0));

        // R4 extreme: most negative LLR with parity already even.
        for (int i = 0; i < 16; i++) l[i*LW +: LW] = 8'sd5;
        l[3*LW +: LW] = -8'sd128;
        l[9*LW +: LW] = -8'sd128;
        run_node(4, 32'h0000_0001, l, 1'b0);

        // R3: sum exactly zero gives all zeros; negative sum gives all ones.
        for (int i = 0; i < 32; i++) l[i*LW +: LW] = (i % 2) ? -8'sd128 : 8'sd127;
        run_node(5, 32'h7FFF_FFFF, l, 1'b0);
        l[0 +: LW] = 8'sd127;
        for (int i = 0; i < 32; i++) l[i*LW +: LW] = (i % 2) ? -8'sd7 : 8'sd7;
        run_node(5, 32'h7FFF_FFFF, l, 1'b0);
        check(beta == '0, "R3 zero sum", 64'(beta), 64'(0));

        // R9: start pokes while busy.
        for (int k = 1; k <= 5; k++) begin
            rnd_llr(l);
            run_node(k, '0, l, 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule